// File: doc/BRIEF.md
# Per-Port Packet Sampling Skip Counter

This block chooses which received packets are captured as statistical samples on each network port. Software writes a random skip count for a port. The port then lets that many eligible packets pass and flags the next eligible packet for capture with a one-cycle strobe. Each port has a 20-bit count-down counter with a one-deep holding register in front of it. Software can therefore queue the next skip count while the current one is still running.

A packet event arrives as a single-cycle strobe. It carries a good-frame flag, a valid-length flag and a destination port mask. Packets injected from the host bus have no counter of their own. They are presented with the mask of the ports they leave on, and each of those ports counts them through its own counter. When a port runs out of counts and nothing is queued, it goes idle and takes no samples until software writes again. A per-port empty bit tells software when the holding register can take a new value.

Top module: `pkt_sample_ctrl`

## Requirements
- R1: After reset every port is idle with an empty holding register: `hold_empty_o` reads all ones, and no packet is sampled until a count has been written.
- R2: A write with `cfg_we_i` high goes to the port given by `cfg_port_i` (index 0 or 1). Only bits 19:0 of `cfg_wdata_i` form the count, and bits 31:20 are ignored. A write to an idle port loads its counter directly, and `hold_empty_o` for that port stays 1.
- R3: With a loaded count N, the port skips N eligible packets and samples the next one. A count of 0 samples the very next eligible packet. `sample_o[p]` is high for exactly one cycle, in the cycle after the packet event.
- R4: A packet event is eligible for port p only when `pkt_good_i`, `pkt_len_ok_i` and `pkt_dst_i[p]` are all 1. An ineligible event neither produces a sample nor changes the count.
- R5: A packet event with several bits set in `pkt_dst_i`, such as one from the host bus, is counted by each addressed port independently, against that port's own count.
- R6: A write to a port whose counter is running goes into its holding register and drives `hold_empty_o` for that port to 0. When that port takes a sample, the held value becomes the new count and `hold_empty_o` returns to 1.
- R7: A write to a port whose holding register is already full replaces the held value. Only the newest value is used.
- R8: After a sample, a port with nothing held goes idle. Further eligible packets are not sampled until a new write arrives.
- R9: When a write and a sample happen on the same port in the same cycle, the held value (if any) is reloaded into the counter and the new write is placed in the holding register. If nothing was held, the new write is loaded into the counter directly. No value is lost or used twice.
- R10: Writes and packets for one port leave the count, sampling and `hold_empty_o` of the other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Skip-count write strobe |
| cfg_port_i | input | 1 | Target port index for the write |
| cfg_wdata_i | input | 32 | Write data, bits 19:0 hold the skip count |
| pkt_valid_i | input | 1 | One-cycle packet event strobe |
| pkt_good_i | input | 1 | Packet received without error |
| pkt_len_ok_i | input | 1 | Packet length within the valid range |
| pkt_dst_i | input | 2 | Ports the packet is received on or sent to |
| sample_o | output | 2 | Per-port capture strobe, one cycle |
| hold_empty_o | output | 2 | Per-port holding register empty status |

## Verification
The two functions that can land in the same cycle on one port are a software write and the counter-exhaustion reload that follows a sample. The bench provokes this by presenting the sampled packet and the write in the same clock. It does this once with a value already held and once with the holding register empty. It then judges the outcome by counting how many later packets each port skips before its next strobe and by reading `hold_empty_o`. This shows which value went to the counter and which was held.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned CNT_W_DEF  = 20;
  localparam int unsigned DATA_W_DEF = 32;

  typedef enum logic {
    SLOT_IDLE  = 1'b0,
    SLOT_ARMED = 1'b1
  } slot_state_e;
endpackage

// File: rtl/pss_cfg_decode.sv
module pss_cfg_decode #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PORT_W    = 1,
  parameter int unsigned DATA_W    = pss_pkg::DATA_W_DEF,
  parameter int unsigned CNT_W     = pss_pkg::CNT_W_DEF
) (
  input  logic                 we_i,
  input  logic [PORT_W-1:0]    port_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [NUM_PORTS-1:0] wr_en_o,
  output logic [CNT_W-1:0]     wr_cnt_o
);
  logic unused_rsvd;

  assign wr_cnt_o    = wdata_i[CNT_W-1:0];
  assign unused_rsvd = ^wdata_i[DATA_W-1:CNT_W];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
    assign wr_en_o[p] = we_i && (port_i == PORT_W'(p));
  end
endmodule

// File: rtl/pss_pkt_qual.sv
module pss_pkt_qual #(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                 valid_i,
  input  logic                 good_i,
  input  logic                 len_ok_i,
  input  logic [NUM_PORTS-1:0] dst_i,
  output logic [NUM_PORTS-1:0] elig_o
);
  logic ok;

  assign ok = valid_i && good_i && len_ok_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign elig_o[p] = ok && dst_i[p];
  end
endmodule

// File: rtl/pss_port_slot.sv
module pss_port_slot
  import pss_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic             elig_i,
  output logic             sample_o,
  output logic             empty_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  slot_state_e      state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] shd_q, shd_n;
  logic             shd_v_q, shd_v_n;
  logic             sample_q;
  logic             armed, at_zero, hit;

  assign armed   = (state_q == SLOT_ARMED);
  assign at_zero = (cnt_q == '0);
  assign hit     = armed && elig_i && at_zero;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    shd_n   = shd_q;
    shd_v_n = shd_v_q;
    if (hit) begin
      // counter frees up: held value first, then the new write
      if (shd_v_q) begin
        cnt_n   = shd_q;
        shd_v_n = wr_en_i;
        if (wr_en_i) shd_n = wr_cnt_i;
      end else if (wr_en_i) begin
        cnt_n = wr_cnt_i;
      end else begin
        state_n = SLOT_IDLE;
      end
    end else if (!armed) begin
      if (wr_en_i) begin
        cnt_n   = wr_cnt_i;
        state_n = SLOT_ARMED;
      end
    end else begin
      if (elig_i) cnt_n = cnt_q - ONE;
      if (wr_en_i) begin
        shd_n   = wr_cnt_i;
        shd_v_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SLOT_IDLE;
      cnt_q    <= '0;
      shd_q    <= '0;
      shd_v_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      shd_q    <= shd_n;
      shd_v_q  <= shd_v_n;
      sample_q <= hit;
    end
  end

  assign sample_o = sample_q;
  assign empty_o  = !shd_v_q;

  // R3
  sample_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(armed && at_zero && elig_i));

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && elig_i && !at_zero) |=> (cnt_q == $past(cnt_q) - ONE));

  // R4
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!elig_i && !wr_en_i) |=> ($stable(cnt_q) && $stable(state_q) && !sample_o));

  // R6
  hold_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shd_v_q |-> armed);

  // R7
  hold_latest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && wr_en_i && !(elig_i && at_zero)) |=> (shd_v_q && shd_q == $past(wr_cnt_i)));

  // R8
  idle_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !wr_en_i) |=> (!sample_o && !armed));
endmodule

// File: rtl/pkt_sample_ctrl.sv
module pkt_sample_ctrl #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  parameter int unsigned DATA_W    = pss_pkg::DATA_W_DEF,
  parameter int unsigned CNT_W     = pss_pkg::CNT_W_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [PORT_W-1:0]    cfg_port_i,
  input  logic [DATA_W-1:0]    cfg_wdata_i,
  input  logic                 pkt_valid_i,
  input  logic                 pkt_good_i,
  input  logic                 pkt_len_ok_i,
  input  logic [NUM_PORTS-1:0] pkt_dst_i,
  output logic [NUM_PORTS-1:0] sample_o,
  output logic [NUM_PORTS-1:0] hold_empty_o
);
  logic [NUM_PORTS-1:0] wr_en;
  logic [CNT_W-1:0]     wr_cnt;
  logic [NUM_PORTS-1:0] elig;

  pss_cfg_decode #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_cfg (
    .we_i    (cfg_we_i),
    .port_i  (cfg_port_i),
    .wdata_i (cfg_wdata_i),
    .wr_en_o (wr_en),
    .wr_cnt_o(wr_cnt)
  );

  pss_pkt_qual #(.NUM_PORTS(NUM_PORTS)) u_qual (
    .valid_i (pkt_valid_i),
    .good_i  (pkt_good_i),
    .len_ok_i(pkt_len_ok_i),
    .dst_i   (pkt_dst_i),
    .elig_o  (elig)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
    pss_port_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en[p]),
      .wr_cnt_i(wr_cnt),
      .elig_i  (elig[p]),
      .sample_o(sample_o[p]),
      .empty_o (hold_empty_o[p])
    );
  end

  // R2
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en) && (cfg_we_i || wr_en == '0));

  // R4
  inelig_no_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_valid_i && pkt_good_i && pkt_len_ok_i) |=> (sample_o == '0));
endmodule

// File: tb/pkt_sample_ctrl_tb.sv
module pkt_sample_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_port = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pkt_v = 1'b0, pkt_good = 1'b0, pkt_lok = 1'b0;
  logic [1:0]  pkt_dst = '0;
  logic [1:0]  sample, hold_empty;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pkt_sample_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_port_i(cfg_port), .cfg_wdata_i(cfg_wdata),
    .pkt_valid_i(pkt_v), .pkt_good_i(pkt_good), .pkt_len_ok_i(pkt_lok),
    .pkt_dst_i(pkt_dst), .sample_o(sample), .hold_empty_o(hold_empty)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(int port, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_port = port[0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one packet event, optionally with a write in the same cycle
  task automatic pkt_ev(bit good, bit lok, logic [1:0] dst, bit wr, int port,
                        logic [31:0] d, output logic [1:0] smp);
    @(negedge clk);
    pkt_v = 1'b1; pkt_good = good; pkt_lok = lok; pkt_dst = dst;
    cfg_we = wr; cfg_port = port[0]; cfg_wdata = d;
    @(posedge clk);
    #1 smp = sample;
    @(negedge clk);
    pkt_v = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic pkt(logic [1:0] dst, output logic [1:0] smp);
    pkt_ev(1'b1, 1'b1, dst, 1'b0, 0, 32'h0, smp);
  endtask

  // expect n silent packets then one sample on the given mask
  task automatic expect_skip(string tag, logic [1:0] dst, int n, logic [1:0] hit);
    logic [1:0] s;
    for (int i = 0; i < n; i++) begin
      pkt(dst, s);
      chk({tag, " skip"}, s, 2'b00);
    end
    pkt(dst, s);
    chk({tag, " hit"}, s, hit);
  endtask

  task automatic t_reset();
    logic [1:0] s;
    chk("R1 empty in reset", hold_empty, 2'b11);
    chk("R1 sample in reset", sample, 2'b00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pkt(2'b11, s);
    chk("R1 no sample before write", s, 2'b00);
  endtask

  task automatic t_basic();
    logic [1:0] s;
    cpu_wr(0, 32'hABC0_0002);
    chk("R2 empty after idle load", hold_empty, 2'b11);
    expect_skip("R3 skip2 rsvd bits", 2'b01, 2, 2'b01);
    pkt(2'b01, s);
    chk("R8 idle after sample", s, 2'b00);
    cpu_wr(1, 32'h0);
    pkt(2'b10, s);
    chk("R3 zero count samples next", s, 2'b10);
  endtask

  task automatic t_inelig();
    logic [1:0] s;
    cpu_wr(0, 32'h1);
    pkt_ev(1'b0, 1'b1, 2'b01, 1'b0, 0, 0, s);
    chk("R4 bad frame", s, 2'b00);
    pkt_ev(1'b1, 1'b0, 2'b01, 1'b0, 0, 0, s);
    chk("R4 bad length", s, 2'b00);
    pkt(2'b10, s);
    chk("R4 other port", s, 2'b00);
    expect_skip("R4 count untouched", 2'b01, 1, 2'b01);
  endtask

  task automatic t_host();
    logic [1:0] s;
    cpu_wr(0, 32'h1);
    cpu_wr(1, 32'h0);
    pkt(2'b11, s);
    chk("R5 multi-dest first", s, 2'b10);
    pkt(2'b11, s);
    chk("R5 multi-dest second", s, 2'b01);
    pkt(2'b11, s);
    chk("R5 both idle", s, 2'b00);
  endtask

  task automatic t_shadow();
    logic [1:0] s;
    cpu_wr(0, 32'h3);
    cpu_wr(0, 32'h0);
    chk("R6 hold full", hold_empty, 2'b10);
    cpu_wr(0, 32'h1);
    chk("R7 still full after overwrite", hold_empty, 2'b10);
    chk("R10 other port empty", hold_empty[1], 1'b1);
    expect_skip("R6 first count", 2'b01, 3, 2'b01);
    chk("R6 empty after reload", hold_empty, 2'b11);
    expect_skip("R7 newest value", 2'b01, 1, 2'b01);
    pkt(2'b01, s);
    chk("R8 idle after held used", s, 2'b00);
  endtask

  task automatic t_collide();
    logic [1:0] s;
    cpu_wr(1, 32'h0);
    cpu_wr(1, 32'h2);
    pkt_ev(1'b1, 1'b1, 2'b10, 1'b1, 1, 32'h0, s);
    chk("R9 sample with write", s, 2'b10);
    chk("R9 new write held", hold_empty, 2'b01);
    expect_skip("R9 held reloaded", 2'b10, 2, 2'b10);
    expect_skip("R9 write used next", 2'b10, 0, 2'b10);
    pkt(2'b10, s);
    chk("R9 idle after", s, 2'b00);
    cpu_wr(1, 32'h0);
    pkt_ev(1'b1, 1'b1, 2'b10, 1'b1, 1, 32'h1, s);
    chk("R9 sample no hold", s, 2'b10);
    chk("R9 direct load keeps empty", hold_empty, 2'b11);
    expect_skip("R9 direct count", 2'b10, 1, 2'b10);
    pkt(2'b10, s);
    chk("R10 port0 untouched", s, 2'b00);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_inelig();
    t_host();
    t_shadow();
    t_collide();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule